// File: doc/BRIEF.md
# Stepwise Adjustable PWM Generator

This block turns a system clock into a fixed-rate pulse train whose high time is set in tenths of the period. A free-running counter splits every output period into a fixed number of clock ticks. Each tick, the counter is compared with a threshold taken from the current duty setting. The result of that comparison goes through a flip-flop before it reaches the pin, so counter codes that are still settling cannot glitch the output. With the default parameters, a 100 MHz clock gives a 10 MHz output.

Two request inputs move the duty setting. One moves it up by one tenth and the other moves it down by one tenth. Each request acts once, on its rising edge. The setting stops at 0 and at full scale and never wraps. A new setting is applied only at the next period boundary, so no cut-short or stretched pulse is ever produced. After reset the setting is half scale.

Top module: `pwm_stepper`

## Requirements
- R1: While reset is held, `pwm_out` is low and `duty_level` reads 5. The count restarts at reset release, so the first output period starts with the clock edge that follows the release.
- R2: An output period is 10 clock cycles long. Within each period, `pwm_out` is high for the first `duty_level` cycles, with `duty_level` counted in tenths from 0 to 10, and low for the rest.
- R3: A rising edge on `duty_up` raises `duty_level` by exactly one. The new value is visible from the clock edge that samples the rise. Holding the input high gives no further steps.
- R4: A rising edge on `duty_down` lowers `duty_level` by exactly one, with the same timing as R3. Holding the input high gives no further steps.
- R5: `duty_level` stays at 10 when raised at 10. At 10, `pwm_out` stays high for the whole period.
- R6: `duty_level` stays at 0 when lowered at 0. At 0, `pwm_out` stays low for the whole period.
- R7: When rising edges on `duty_up` and `duty_down` are sampled in the same cycle, `duty_level` does not change.
- R8: A change of `duty_level` during a period does not alter that period. The output uses the new value from the next period boundary on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_up | input | 1 | Request to raise the duty setting by one step (edge-sensitive) |
| duty_down | input | 1 | Request to lower the duty setting by one step (edge-sensitive) |
| pwm_out | output | 1 | Registered pulse-width-modulated output |
| duty_level | output | 4 | Requested duty setting, in tenths of the period (0 to 10) |

## Verification
The assertions assume that both request inputs are already synchronous to `clk` and free of bounce, because each sampled rising edge is treated as one deliberate request. The bench changes the requests only on falling clock edges and holds each level for at least one full cycle, so every rise is sampled exactly once. The mid-period change scenarios drive their request several cycles away from the period's last tick, so that the request edge and the boundary edge never fall on the same clock.

// File: rtl/pwm_stepper_pkg.sv
package pwm_stepper_pkg;

    // Default division ratio and number of duty steps per period
    localparam int unsigned DEF_PERIOD = 10;
    localparam int unsigned DEF_STEPS  = 10;

    // Decoded action on the duty setting for one cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_RAISE = 2'd1,
        OP_LOWER = 2'd2
    } step_op_t;

    // Edge events from the two request inputs
    typedef struct packed {
        logic up;
        logic dn;
    } step_req_t;

    // Opposing requests cancel each other
    function automatic step_op_t decode_op(input step_req_t req);
        if (req.up && !req.dn) return OP_RAISE;
        if (req.dn && !req.up) return OP_LOWER;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/pwm_rise_det.sv
module pwm_rise_det #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev;

    // Track the level even in reset, so that a held input gives no event at release
    always_ff @(posedge clk) begin
        prev <= lvl;
    end

    assign rise = lvl & ~prev;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (rst)
                rise[i] |=> !rise[i]) else $error("rise held on bit %0d", i); // R3
        end
    endgenerate

endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
    parameter int unsigned PERIOD = pwm_stepper_pkg::DEF_PERIOD,
    localparam int unsigned CW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    assign wrap = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST) else $error("counter out of range"); // R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST) |=> (cnt == '0)) else $error("counter did not wrap"); // R2

endmodule

// File: rtl/pwm_duty_ctrl.sv
module pwm_duty_ctrl
    import pwm_stepper_pkg::*;
#(
    parameter int unsigned STEPS = DEF_STEPS,
    localparam int unsigned DW   = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  step_req_t     ev,
    output logic [DW-1:0] level
);

    localparam logic [DW-1:0] TOP  = DW'(STEPS);
    localparam logic [DW-1:0] HALF = DW'(STEPS / 2);

    step_op_t op;
    assign op = decode_op(ev);

    // Saturating up/down counter over the step range
    always_ff @(posedge clk) begin
        if (rst) begin
            level <= HALF;
        end else begin
            unique case (op)
                OP_RAISE: if (level != TOP)  level <= level + 1'b1;
                OP_LOWER: if (level != '0)   level <= level - 1'b1;
                default:  level <= level;
            endcase
        end
    end

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (ev.up && !ev.dn && level != TOP) |=> (level == DW'($past(level) + 1'b1)))
        else $error("raise did not add one step"); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (ev.dn && !ev.up && level != '0) |=> (level == DW'($past(level) - 1'b1)))
        else $error("lower did not remove one step"); // R4
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
        (ev.up && !ev.dn && level == TOP) |=> (level == TOP))
        else $error("duty wrapped above full scale"); // R5
    AST_SAT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ev.dn && !ev.up && level == '0) |=> (level == '0))
        else $error("duty wrapped below zero"); // R6
    AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (ev.up && ev.dn) |=> $stable(level))
        else $error("simultaneous requests changed duty"); // R7
    AST_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ev.up && !ev.dn) |=> $stable(level))
        else $error("duty moved without a request"); // R3
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        level <= TOP) else $error("duty out of range"); // R5

endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper #(
    parameter int unsigned PERIOD = pwm_stepper_pkg::DEF_PERIOD,
    parameter int unsigned STEPS  = pwm_stepper_pkg::DEF_STEPS,
    localparam int unsigned CW    = $clog2(PERIOD),
    localparam int unsigned DW    = $clog2(STEPS + 1),
    localparam int unsigned TW    = $clog2(PERIOD + 1),
    localparam int unsigned UNIT  = PERIOD / STEPS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  logic          wrap,
    input  logic [DW-1:0] level,
    output logic          pwm_q
);

    localparam logic [DW-1:0] TOP  = DW'(STEPS);
    localparam logic [DW-1:0] HALF = DW'(STEPS / 2);

    logic [DW-1:0] act;
    logic [TW-1:0] thr;

    // Duty in force for the running period; reloaded only at the last tick
    always_ff @(posedge clk) begin
        if (rst)       act <= HALF;
        else if (wrap) act <= level;
    end

    assign thr = TW'(act) * TW'(UNIT);

    // Registered comparison keeps transient counter codes off the pin
    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= (TW'(cnt) < thr);
    end

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act)) else $error("duty changed inside a period"); // R8
    AST_ACT_LOAD: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (act == $past(level))) else $error("duty not loaded at boundary"); // R8
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (act == TOP) |=> pwm_q) else $error("full duty gave a low cycle"); // R5
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        (act == '0) |=> !pwm_q) else $error("zero duty gave a high cycle"); // R6

endmodule

// File: rtl/pwm_stepper.sv
module pwm_stepper
    import pwm_stepper_pkg::*;
#(
    parameter int unsigned PERIOD = DEF_PERIOD,
    parameter int unsigned STEPS  = DEF_STEPS,
    localparam int unsigned CW    = $clog2(PERIOD),
    localparam int unsigned DW    = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          duty_up,
    input  logic          duty_down,
    output logic          pwm_out,
    output logic [DW-1:0] duty_level
);

    initial begin
        if (PERIOD % STEPS != 0) $error("PERIOD must be a multiple of STEPS");
        if (PERIOD < 2)          $error("PERIOD must be at least 2");
    end

    logic [1:0]    rise;
    step_req_t     ev;
    logic [CW-1:0] cnt;
    logic          wrap;

    pwm_rise_det #(.N(2)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({duty_up, duty_down}),
        .rise (rise)
    );

    assign ev.up = rise[1];
    assign ev.dn = rise[0];

    pwm_duty_ctrl #(.STEPS(STEPS)) u_duty (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .level (duty_level)
    );

    pwm_period_cnt #(.PERIOD(PERIOD)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .cnt  (cnt),
        .wrap (wrap)
    );

    pwm_shaper #(.PERIOD(PERIOD), .STEPS(STEPS)) u_shape (
        .clk   (clk),
        .rst   (rst),
        .cnt   (cnt),
        .wrap  (wrap),
        .level (duty_level),
        .pwm_q (pwm_out)
    );

endmodule

// File: tb/pwm_stepper_test.sv
module pwm_stepper_test;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 10;
    localparam int S          = 10;
    localparam int U          = P / S;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       duty_up = 1'b0;
    logic       duty_down = 1'b0;
    logic       pwm_out;
    logic [3:0] duty_level;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    bit done   = 1'b0;

    pwm_stepper uut (
        .clk        (clk),
        .rst        (rst),
        .duty_up    (duty_up),
        .duty_down  (duty_down),
        .pwm_out    (pwm_out),
        .duty_level (duty_level)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Clock edges since reset release; edge n carries output slot (n-1) mod P
    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic align();
        @(negedge clk);
        while (edges % P != 1) @(negedge clk);
    endtask

    // Checks one whole output period against duty d (starting at a boundary)
    task automatic check_period(input int d, input string req);
        int bad = 0;
        int first = -1;
        int got = 0;
        for (int i = 0; i < P; i++) begin
            got = pwm_out;
            if (got != int'(i < d * U)) begin
                bad++;
                if (first < 0) first = i;
            end
            @(negedge clk);
        end
        if (bad != 0)
            $display("FAIL %s: mismatch at slot %0d, duty %0d, %0d bad slots", req, first, d, bad);
        checks++;
        if (bad != 0) errors++;
    endtask

    // Skip one period so any new setting is in force, then measure
    task automatic measure(input int d, input string req);
        align();
        repeat (P) @(negedge clk);
        check_period(d, req);
    endtask

    task automatic pulse(input bit up, input bit dn, input int hold);
        duty_up   = up;
        duty_down = dn;
        repeat (hold) @(negedge clk);
        duty_up   = 1'b0;
        duty_down = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 pwm in reset", pwm_out, 0);
        check(duty_level == 4'd5, "R1 duty in reset", duty_level, 5);
        rst = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b1, "R1 first slot high", pwm_out, 1);
        align();
        check_period(5, "R1 R2 default period");
    endtask

    task automatic t_raise();
        pulse(1'b1, 1'b0, 1);
        check(duty_level == 4'd6, "R3 single raise", duty_level, 6);
        measure(6, "R2 duty 6");
        pulse(1'b1, 1'b0, 7);
        check(duty_level == 4'd7, "R3 held raise", duty_level, 7);
        measure(7, "R2 duty 7");
    endtask

    task automatic t_lower();
        pulse(1'b0, 1'b1, 1);
        pulse(1'b0, 1'b1, 12);
        pulse(1'b0, 1'b1, 2);
        check(duty_level == 4'd4, "R4 three lowers", duty_level, 4);
        measure(4, "R2 duty 4");
    endtask

    task automatic t_top();
        for (int k = 0; k < 8; k++) pulse(1'b1, 1'b0, 1);
        check(duty_level == 4'd10, "R5 saturate top", duty_level, 10);
        pulse(1'b1, 1'b0, 1);
        check(duty_level == 4'd10, "R5 raise at top", duty_level, 10);
        measure(10, "R5 full period high");
    endtask

    task automatic t_zero();
        for (int k = 0; k < 12; k++) pulse(1'b0, 1'b1, 1);
        check(duty_level == 4'd0, "R6 saturate zero", duty_level, 0);
        measure(0, "R6 full period low");
    endtask

    task automatic t_both();
        for (int k = 0; k < 3; k++) pulse(1'b1, 1'b0, 1);
        check(duty_level == 4'd3, "R3 raise to 3", duty_level, 3);
        pulse(1'b1, 1'b1, 2);
        check(duty_level == 4'd3, "R7 both cancel", duty_level, 3);
        measure(3, "R7 duty 3 kept");
    endtask

    task automatic t_boundary();
        int bad = 0;
        align();
        for (int i = 0; i < P; i++) begin
            if (pwm_out != (i < 3 * U)) bad++;
            if (i == 2) duty_up = 1'b1;
            if (i == 4) duty_up = 1'b0;
            @(negedge clk);
        end
        check(bad == 0, "R8 running period unchanged", bad, 0);
        check(duty_level == 4'd4, "R8 setting updated", duty_level, 4);
        check_period(4, "R8 next period uses new duty");
        bad = 0;
        for (int i = 0; i < P; i++) begin
            if (pwm_out != (i < 4 * U)) bad++;
            if (i == 5) duty_down = 1'b1;
            if (i == 7) duty_down = 1'b0;
            @(negedge clk);
        end
        check(bad == 0, "R8 period kept during lower", bad, 0);
        check_period(3, "R8 lowered from boundary");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_raise();
        t_lower();
        t_top();
        t_zero();
        t_both();
        t_boundary();
        finish_run();
    end

endmodule